// File: doc/BRIEF.md
# Multi-Set Coefficient Bank

This block holds the filter coefficients for two filter cells, A and B. Each cell has 32 sets of four coefficients, and each coefficient is 10 bits wide. A processor-style port loads the storage. It has a 9-bit address, a 10-bit data bus and a write strobe. The strobe's rising edge captures the address and data. The strobe has no timing relation to the sample clock.

Each captured write passes into the sample-clock domain through a toggle flag and a two-flop synchroniser, and only then updates the storage. The whole array is held in flip-flops, so it can be read every cycle.

A 5-bit set selector is registered on each rising edge of the sample clock. Both cells then present all four coefficients of the selected set at once. Because the selector can take a new value on every cycle, the datapath can step through sets for polyphase or adaptive filtering.

Top module: `coef_bank`

## Requirements
- R1: While reset is asserted, and after it is released, every coefficient of every set in both banks reads as zero until a write lands.
- R2: A mapped write becomes visible at the outputs by the fourth rising sample-clock edge after the strobe's rising edge, provided that set is selected.
- R3: The write address is decoded as follows.
  - Bit 7 picks the bank: 0 is bank A, 1 is bank B.
  - Bits 6:2 give the set index.
  - Bits 1:0 give the tap index.
  - Tap t of a bank appears on bits [10t+9:10t] of that bank's output.
- R4: A write with address bit 8 set changes no stored coefficient.
- R5: The outputs show the set chosen by the selector value sampled at the most recent rising clock edge. A change of the selector between edges does not show until the next edge.
- R6: If no write lands and the selector keeps the same value, the outputs hold steady from one cycle to the next.
- R7: Two writes spaced at least five sample-clock periods apart both land.
- R8: A write replaces only the addressed tap of the addressed set and bank. All other stored values are left as they were.
- R9: The selector may take a different set on every clock cycle, and the outputs follow it each cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_strobe | input | 1 | Write strobe; the rising edge captures the address and data |
| wr_addr | input | 9 | Write address |
| wr_data | input | 10 | Coefficient value to store |
| set_sel | input | 5 | Coefficient set select, registered on clk |
| coef_a | output | 40 | The four taps of the selected set, bank A |
| coef_b | output | 40 | The four taps of the selected set, bank B |

## Verification
Each fault in this block shows up at the ports, and quickly:
- A corrupted storage cell shows on the next cycle in which its set is selected.
- A wrong address decode puts a value in the wrong tap, set or bank. A full-width comparison against a reference model reveals it on the first read after the write.
- A broken synchroniser shows as a write that never lands within four edges, or lands twice.
- A selector that is not registered shows within the same cycle, because the outputs move before the clock edge.

// File: rtl/coef_bank.sv
module coef_bank #(
  parameter int DW    = 10,
  parameter int AW    = 9,
  parameter int SEL_W = 5,
  parameter int TAP_W = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_strobe,
  input  logic [AW-1:0]               wr_addr,
  input  logic [DW-1:0]               wr_data,
  input  logic [SEL_W-1:0]            set_sel,
  output logic [(1<<TAP_W)*DW-1:0]    coef_a,
  output logic [(1<<TAP_W)*DW-1:0]    coef_b
);
  localparam int NSET     = 1 << SEL_W;
  localparam int NTAP     = 1 << TAP_W;
  localparam int BANK_BIT = SEL_W + TAP_W;

  logic [AW-1:0]    hold_addr;
  logic [DW-1:0]    hold_data;
  logic             wr_tog;
  logic [2:0]       sync;
  logic [SEL_W-1:0] sel_q;
  logic [DW-1:0]    mem_a [NSET][NTAP];
  logic [DW-1:0]    mem_b [NSET][NTAP];

  always_ff @(posedge wr_strobe or negedge rst_n) begin
    if (!rst_n) begin
      hold_addr <= '0;
      hold_data <= '0;
      wr_tog    <= 1'b0;
    end else begin
      hold_addr <= wr_addr;
      hold_data <= wr_data;
      wr_tog    <= ~wr_tog;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync <= '0;
    else        sync <= {sync[1:0], wr_tog};
  end

  wire wr_commit = sync[2] ^ sync[1];
  wire mapped    = (hold_addr[AW-1:BANK_BIT+1] == '0);
  wire [SEL_W-1:0] w_set = hold_addr[BANK_BIT-1:TAP_W];
  wire [TAP_W-1:0] w_tap = hold_addr[TAP_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      for (int s = 0; s < NSET; s++)
        for (int t = 0; t < NTAP; t++) begin
          mem_a[s][t] <= '0;
          mem_b[s][t] <= '0;
        end
    end else begin
      sel_q <= set_sel;
      if (wr_commit && mapped) begin
        if (hold_addr[BANK_BIT]) mem_b[w_set][w_tap] <= hold_data;
        else                     mem_a[w_set][w_tap] <= hold_data;
      end
    end
  end

  for (genvar t = 0; t < NTAP; t++) begin : g_tap
    assign coef_a[t*DW +: DW] = mem_a[sel_q][t];
    assign coef_b[t*DW +: DW] = mem_b[sel_q][t];
  end
endmodule

// File: rtl/coef_bank_chk.sv
module coef_bank_chk #(
  parameter int AW = 9,
  parameter int SW = 5,
  parameter int OW = 40
) (
  input logic          clk,
  input logic          rst_n,
  input logic [SW-1:0] set_sel,
  input logic [OW-1:0] coef_a,
  input logic [OW-1:0] coef_b,
  input logic          commit,
  input logic [AW-1:0] hold_addr
);
  logic wrote, armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrote <= 1'b0;
      armed <= 1'b0;
    end else begin
      armed <= 1'b1;
      if (commit && !hold_addr[AW-1]) wrote <= 1'b1;
    end
  end

  AST_RESET_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !wrote |-> (coef_a == '0 && coef_b == '0)); // R1

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !commit && $stable(set_sel)) |=> ($stable(coef_a) && $stable(coef_b))); // R6

  AST_UNMAPPED_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && commit && hold_addr[AW-1] && $stable(set_sel)) |=> ($stable(coef_a) && $stable(coef_b))); // R4

  AST_SINGLE_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !commit); // R7
endmodule

bind coef_bank coef_bank_chk #(.AW(AW), .SW(SEL_W), .OW((1<<TAP_W)*DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .set_sel(set_sel), .coef_a(coef_a), .coef_b(coef_b),
  .commit(wr_commit), .hold_addr(hold_addr));

// File: tb/tb_coef_bank.sv
`timescale 1ns/1ps
module tb_coef_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_strobe = 1'b0;
  logic [8:0]  wr_addr = '0;
  logic [9:0]  wr_data = '0;
  logic [4:0]  set_sel = '0;
  logic [39:0] coef_a, coef_b;

  int checks = 0;
  int fails  = 0;
  logic [9:0] ref_a [32][4];
  logic [9:0] ref_b [32][4];

  always #2.5 clk = ~clk;

  coef_bank dut (.clk(clk), .rst_n(rst_n), .wr_strobe(wr_strobe), .wr_addr(wr_addr),
                 .wr_data(wr_data), .set_sel(set_sel), .coef_a(coef_a), .coef_b(coef_b));

  localparam int NV = 10;
  localparam logic [18:0] VEC [NV] = '{
    {9'h000, 10'h155}, {9'h07F, 10'h3FF}, {9'h080, 10'h200}, {9'h0C6, 10'h0AA},
    {9'h044, 10'h001}, {9'h100, 10'h2EE}, {9'h1FF, 10'h123}, {9'h000, 10'h321},
    {9'h0FF, 10'h1C3}, {9'h045, 10'h07E}
  };

  function automatic logic [39:0] pack_a(input int s);
    return {ref_a[s][3], ref_a[s][2], ref_a[s][1], ref_a[s][0]};
  endfunction
  function automatic logic [39:0] pack_b(input int s);
    return {ref_b[s][3], ref_b[s][2], ref_b[s][1], ref_b[s][0]};
  endfunction

  task automatic check(input logic [39:0] act, input logic [39:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [8:0] a, input logic [9:0] d);
    wr_addr = a;
    wr_data = d;
    #0.5 wr_strobe = 1'b1;
    #1.0 wr_strobe = 1'b0;
    if (!a[8]) begin
      if (a[7]) ref_b[a[6:2]][a[1:0]] = d;
      else      ref_a[a[6:2]][a[1:0]] = d;
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int s = 0; s < 32; s++)
      for (int t = 0; t < 4; t++) begin
        ref_a[s][t] = '0;
        ref_b[s][t] = '0;
      end
    #1;
    check(coef_a, 40'h0, "R1 during reset");
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int s = 0; s < 32; s += 15) begin
      set_sel = 5'(s);
      @(negedge clk);
      check(coef_a, 40'h0, "R1 bank A after reset");
      check(coef_b, 40'h0, "R1 bank B after reset");
    end

    // R3 R4 R8: table of writes checked against the reference model
    for (int i = 0; i < NV; i++) begin
      do_write(VEC[i][18:10], VEC[i][9:0]);
      repeat (5) @(negedge clk);
      set_sel = VEC[i][16:12];
      @(negedge clk);
      check(coef_a, pack_a(int'(VEC[i][16:12])), VEC[i][18] ? "R4 unmapped A" : "R3/R8 bank A");
      check(coef_b, pack_b(int'(VEC[i][16:12])), VEC[i][18] ? "R4 unmapped B" : "R3/R8 bank B");
    end

    // R2: write latency with the target set already selected
    set_sel = 5'd9;
    @(negedge clk);
    do_write(9'h025, 10'h0AB);
    repeat (4) @(negedge clk);
    check(coef_a, pack_a(9), "R2 write latency");

    // R7: two writes five periods apart
    do_write(9'h0A6, 10'h111);
    repeat (5) @(negedge clk);
    do_write(9'h0A7, 10'h222);
    repeat (5) @(negedge clk);
    set_sel = 5'd9;
    @(negedge clk);
    check(coef_b, pack_b(9), "R7 spaced writes");

    // R5 R9: selector changes every cycle
    begin
      int pat [6] = '{0, 31, 17, 9, 16, 0};
      int prev = 9;
      for (int k = 0; k < 6; k++) begin
        set_sel = 5'(pat[k]);
        #1;
        check(coef_a, pack_a(prev), "R5 selector registered");
        @(negedge clk);
        check(coef_a, pack_a(pat[k]), "R9 per-cycle switch A");
        check(coef_b, pack_b(pat[k]), "R9 per-cycle switch B");
        prev = pat[k];
      end
    end

    // R6: hold
    set_sel = 5'd31;
    @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(coef_a, pack_a(31), "R6 stable");
    end

    // R1: reset again clears storage
    rst_n = 1'b0;
    #1;
    check(coef_a, 40'h0, "R1 reset clears A");
    check(coef_b, 40'h0, "R1 reset clears B");
    @(negedge clk);
    rst_n = 1'b1;
    set_sel = 5'd17;
    @(negedge clk);
    check(coef_b, 40'h0, "R1 after second reset");
    finish_run();
  end
endmodule